// File: doc/BRIEF.md
# Three-Wire 24-Bit Serial Register Port

This block is a serial master for reaching the 16-bit control registers of an external display bridge over a three-wire link. The link has chip select, a serial clock and a data-out line, plus an optional data-in line. A client places a register index, a read/write flag and, for writes, a 16-bit value on the command inputs, then pulses a start strobe. The block runs the whole access on its own and lowers its busy flag when the access is over. For a read, the 16-bit result is then waiting on the read-data output.

Every access consists of two 24-bit frames, and each frame is sent with its most significant bit first. The first frame selects the register. The second frame either carries the value to be written or clocks the register contents back in. Bit timing comes from a half-bit period given in system clock cycles. Each chip-select guard interval lasts two half-bit periods. A parameter removes the data-in path for boards that cannot read back; on such a build every read returns zero.

Top module: `spi24_reg_port`

## Requirements
- R1: After reset, cs_n_o, sck_o and mosi_o are 1, busy_o is 0 and rdata_o is 0. All three link outputs stay 1 whenever busy_o is 0.
- R2: A write sends the frame {8'h70, 8'h00, index} and then the frame {8'h72, value[15:0]}. Each frame is 24 bits, most significant bit first.
- R3: A read sends the frame {8'h70, 8'h00, index} and then the frame {8'h73, 16'h0000}.
- R4: A read returns on rdata_o the last 16 bits sampled on miso_i during the second frame, first-sampled bit most significant. Each bit is sampled in the final cycle of its sck_o low phase.
- R5: For each bit, sck_o is low for HALF_CYC cycles and then high for HALF_CYC cycles. mosi_o takes the bit's value when sck_o falls and holds it while sck_o is high.
- R6: In every frame, chip select is low for 2*HALF_CYC cycles before the first sck_o fall. It stays low for 2*HALF_CYC cycles after the last high phase ends, so it is low for 3*HALF_CYC cycles after the last sck_o rise. It is then high for 2*HALF_CYC cycles before the second frame begins or before busy_o drops. sck_o is never low while chip select is high.
- R7: busy_o rises in the cycle after a start strobe accepted while idle. It stays high for exactly 108*HALF_CYC cycles.
- R8: A start strobe that arrives while busy_o is high has no effect. The running access is not altered and no further access follows it.
- R9: rdata_o changes only in the cycle in which busy_o falls at the end of a read. A write leaves it unchanged.
- R10: With HAS_SDI = 0, miso_i is ignored and every read returns 16'h0000.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that begins an access |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| idx_i | input | 8 | Register index |
| wdata_i | input | 16 | Value to write |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 16 | Result of the most recent read |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out, idles high |
| miso_i | input | 1 | Serial data in (ignored when HAS_SDI = 0) |

## Verification
The bench builds two copies of the block. The main copy uses HALF_CYC = 2 with the data-in path present. The second copy uses HALF_CYC = 3 without it. The short half-bit period keeps each 216-cycle access cheap, so the bench can count every phase length of every frame exactly and compare each frame with a scoreboard. The odd period of the second copy catches any scaling of the guard and busy lengths that is right only by accident. Because both copies share one data-in line, which is held high, a build that wrongly keeps its data-in path would return all ones instead of zero.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

  localparam int FRAME_W = 24;
  localparam int IDX_W   = 8;
  localparam int DATA_W  = 16;
  localparam int BIT_W   = $clog2(FRAME_W);

  localparam logic [7:0] OP_SELECT = 8'h70;
  localparam logic [7:0] OP_WRITE  = 8'h72;
  localparam logic [7:0] OP_READ   = 8'h73;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_TAIL,
    PH_GAP
  } phase_e;

  function automatic logic [FRAME_W-1:0] select_frame(input logic [IDX_W-1:0] idx);
    return {OP_SELECT, 8'h00, idx};
  endfunction

  function automatic logic [FRAME_W-1:0] payload_frame(input logic rd,
                                                       input logic [DATA_W-1:0] wd);
    return rd ? {OP_READ, {DATA_W{1'b0}}} : {OP_WRITE, wd};
  endfunction

endpackage

// File: rtl/spi24_tick.sv
module spi24_tick #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // Loading N makes the phase last N cycles including the transition edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/spi24_shift.sv
module spi24_shift
  import spi24_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               emit_i,
  input  logic               capture_i,
  input  logic               park_i,
  input  logic               sdi_i,
  output logic               mosi_o,
  output logic [DATA_W-1:0]  rx_o
);

  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic               mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b1;
    end else begin
      if (load_i) begin
        tx_q <= frame_i;
      end else if (emit_i) begin
        mosi_q <= tx_q[FRAME_W-1];
        tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (park_i) begin
        mosi_q <= 1'b1;
      end
      // Older bits fall off the top; the last DATA_W samples remain.
      if (capture_i) begin
        rx_q <= {rx_q[DATA_W-2:0], sdi_i};
      end
    end
  end

  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/spi24_seq.sv
module spi24_seq
  import spi24_pkg::*;
#(
  parameter int HALF_CYC = 100,
  parameter int CNT_W    = $clog2(2 * HALF_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  rx_i,
  input  logic               tdone_i,
  output logic               tload_o,
  output logic [CNT_W-1:0]   tlen_o,
  output logic               ld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               emit_o,
  output logic               cap_o,
  output logic               park_o,
  output logic               busy_o,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam logic [CNT_W-1:0] HALF_LEN  = CNT_W'(HALF_CYC);
  localparam logic [CNT_W-1:0] GUARD_LEN = CNT_W'(2 * HALF_CYC);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

  phase_e             ph_q;
  logic               second_q;
  logic               rd_q;
  logic [DATA_W-1:0]  wd_q;
  logic [BIT_W-1:0]   bit_q;
  logic               busy_q, cs_n_q, sck_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               last_bit;

  assign last_bit = (bit_q == LAST_BIT);

  always_comb begin
    tload_o = 1'b0;
    tlen_o  = HALF_LEN;
    ld_o    = 1'b0;
    frame_o = '0;
    emit_o  = 1'b0;
    cap_o   = 1'b0;
    park_o  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ld_o    = 1'b1;
        frame_o = select_frame(idx_i);
        tload_o = 1'b1;
        tlen_o  = GUARD_LEN;
      end
      PH_LEAD: if (tdone_i) begin
        emit_o  = 1'b1;
        tload_o = 1'b1;
      end
      PH_LOW: if (tdone_i) begin
        cap_o   = 1'b1;
        tload_o = 1'b1;
      end
      PH_HIGH: if (tdone_i) begin
        tload_o = 1'b1;
        if (last_bit) tlen_o = GUARD_LEN;
        else          emit_o = 1'b1;
      end
      PH_TAIL: if (tdone_i) begin
        park_o  = 1'b1;
        tload_o = 1'b1;
        tlen_o  = GUARD_LEN;
      end
      PH_GAP: if (tdone_i && !second_q) begin
        ld_o    = 1'b1;
        frame_o = payload_frame(rd_q, wd_q);
        tload_o = 1'b1;
        tlen_o  = GUARD_LEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      second_q <= 1'b0;
      rd_q     <= 1'b0;
      wd_q     <= '0;
      bit_q    <= '0;
      busy_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      sck_q    <= 1'b1;
      rdata_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q     <= PH_LEAD;
          busy_q   <= 1'b1;
          cs_n_q   <= 1'b0;
          second_q <= 1'b0;
          rd_q     <= rd_i;
          wd_q     <= wdata_i;
        end
        PH_LEAD: if (tdone_i) begin
          ph_q  <= PH_LOW;
          sck_q <= 1'b0;
          bit_q <= '0;
        end
        PH_LOW: if (tdone_i) begin
          ph_q  <= PH_HIGH;
          sck_q <= 1'b1;
        end
        PH_HIGH: if (tdone_i) begin
          if (last_bit) begin
            ph_q <= PH_TAIL;
          end else begin
            ph_q  <= PH_LOW;
            sck_q <= 1'b0;
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_TAIL: if (tdone_i) begin
          ph_q   <= PH_GAP;
          cs_n_q <= 1'b1;
        end
        PH_GAP: if (tdone_i) begin
          if (!second_q) begin
            second_q <= 1'b1;
            ph_q     <= PH_LEAD;
            cs_n_q   <= 1'b0;
          end else begin
            ph_q   <= PH_IDLE;
            busy_q <= 1'b0;
            if (rd_q) rdata_q <= rx_i;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign cs_n_o  = cs_n_q;
  assign sck_o   = sck_q;
  assign rdata_o = rdata_q;

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cs_n_q && sck_q)); // R1
  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !sck_q |-> !cs_n_q); // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q); // R7
  AST_SECOND_KEEPS_OP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> (rd_q == $past(rd_q))); // R8

endmodule

// File: rtl/spi24_reg_port.sv
module spi24_reg_port
  import spi24_pkg::*;
#(
  parameter int HALF_CYC = 100,
  parameter bit HAS_SDI  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [7:0]  idx_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic [15:0] rdata_o,
  output logic        cs_n_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i
);

  localparam int CNT_W = $clog2(2 * HALF_CYC + 1);

  logic               tload, tdone;
  logic [CNT_W-1:0]   tlen;
  logic               ld, emit, cap, park, sdi;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  rx;

  generate
    if (HAS_SDI) begin : g_sdi
      assign sdi = miso_i;
    end else begin : g_no_sdi
      assign sdi = 1'b0;
    end
  endgenerate

  spi24_tick #(.CNT_W(CNT_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tload),
    .len_i     (tlen),
    .expired_o (tdone)
  );

  spi24_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (ld),
    .frame_i   (frame),
    .emit_i    (emit),
    .capture_i (cap),
    .park_i    (park),
    .sdi_i     (sdi),
    .mosi_o    (mosi_o),
    .rx_o      (rx)
  );

  spi24_seq #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .rd_i    (rd_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .rx_i    (rx),
    .tdone_i (tdone),
    .tload_o (tload),
    .tlen_o  (tlen),
    .ld_o    (ld),
    .frame_o (frame),
    .emit_o  (emit),
    .cap_o   (cap),
    .park_o  (park),
    .busy_o  (busy_o),
    .cs_n_o  (cs_n_o),
    .sck_o   (sck_o),
    .rdata_o (rdata_o)
  );

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy_o) |-> $stable(rdata_o)); // R9

endmodule

// File: tb/spi24_reg_port_tb.sv
module spi24_reg_port_tb;

  localparam int H  = 2;
  localparam int HN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        start, rd, start_nm;
  logic [7:0]  idx;
  logic [15:0] wd;
  logic        busy, cs_n, sck, mosi, miso, busy_nm, cs_nm, sck_nm, mosi_nm;
  logic [15:0] rdata, rdata_nm;
  logic [23:0] resp_word;

  int total = 0;
  int bad   = 0;
  logic [23:0] exp_q[$];

  spi24_reg_port #(.HALF_CYC(H), .HAS_SDI(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .rd_i(rd), .idx_i(idx), .wdata_i(wd),
    .busy_o(busy), .rdata_o(rdata), .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso));

  spi24_reg_port #(.HALF_CYC(HN), .HAS_SDI(1'b0)) u_dut_nm (
    .clk(clk), .rst(rst), .start_i(start_nm), .rd_i(1'b1), .idx_i(8'h3C),
    .wdata_i(16'h0), .busy_o(busy_nm), .rdata_o(rdata_nm), .cs_n_o(cs_nm),
    .sck_o(sck_nm), .mosi_o(mosi_nm), .miso_i(miso));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: samples at the falling clock edge, away from the active edge.
  int nbits = 0, leadc = 0, lowc = 0, tailc = 0;
  logic [23:0] cap;
  logic prev_cs = 1'b1, prev_sck = 1'b1;

  assign miso = (!cs_n && nbits < 24) ? resp_word[5'(23 - nbits)] : 1'b1;

  always @(negedge clk) begin
    if (rst) begin
      nbits = 0; leadc = 0; lowc = 0; tailc = 0; cap = '0;
      prev_cs = 1'b1; prev_sck = 1'b1;
    end else begin
      if (!cs_n && prev_cs) begin
        nbits = 0; leadc = 0; cap = '0;
      end
      if (!cs_n && sck && nbits == 0) leadc++;
      if (!sck && prev_sck) begin
        if (nbits == 0) chk(leadc == 2 * H, "R6 lead guard", leadc, 2 * H);
        lowc = 0;
      end
      if (!sck) lowc++;
      if (sck && !prev_sck) begin
        chk(lowc == H, "R5 low phase", lowc, H);
        cap = {cap[22:0], mosi};
        nbits++;
        tailc = 0;
      end
      if (!cs_n && sck && nbits > 0) tailc++;
      if (cs_n && !prev_cs) begin
        chk(nbits == 24, "R2 frame length", nbits, 24);
        chk(tailc == 3 * H, "R6 tail guard", tailc, 3 * H);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected frame", cap, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(cap == e, "R2/R3 frame content", cap, e);
        end
      end
      prev_cs = cs_n; prev_sck = sck;
    end
  end

  logic [15:0] exp_rdata = '0;

  // Driver: pushes the expected frames, then runs one access.
  task automatic access(input bit r, input logic [7:0] i, input logic [15:0] v,
                        input logic [23:0] resp, input bit inject);
    int cyc;
    @(negedge clk);
    resp_word = resp;
    exp_q.push_back({8'h70, 8'h00, i});
    exp_q.push_back(r ? {8'h73, 16'h0000} : {8'h72, v});
    start = 1'b1; rd = r; idx = i; wd = v;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy rises", busy, 1);
    cyc = 1;
    while (busy) begin
      if (inject && (cyc == 30 || cyc == 150)) begin
        start = 1'b1; rd = ~r; idx = ~i; wd = ~v;   // R8: ignored strobe
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (busy) cyc++;
    end
    start = 1'b0;
    chk(cyc == 108 * H, "R7 busy length", cyc, 108 * H);
    if (r) exp_rdata = resp[15:0];
    chk(rdata == exp_rdata, r ? "R4 read data" : "R9 rdata kept", rdata, exp_rdata);
    repeat (6) @(negedge clk);
    chk(!busy && cs_n, "R8 no restart", {busy, cs_n}, 2'b01);
    chk(exp_q.size() == 0, "R2/R3 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    start = 0; rd = 0; idx = 0; wd = 0; start_nm = 0; resp_word = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sck && mosi, "R1 idle lines", {cs_n, sck, mosi}, 3'b111);
    chk(!busy && rdata == 0, "R1 reset outputs", {busy, rdata}, 0);

    access(1'b0, 8'hB7, 16'h0301, 24'hFFFFFF, 1'b0);   // R2 write
    access(1'b1, 8'hB0, 16'h0000, 24'hC3_2828, 1'b0);  // R3 R4 read
    access(1'b0, 8'hBA, 16'hA55A, 24'h000000, 1'b1);   // R8 R9 write with strobes
    access(1'b1, 8'h01, 16'h0000, 24'h5A_F00F, 1'b1);  // R4 R8 read with strobes
    access(1'b1, 8'hFF, 16'h0000, 24'hFF_0001, 1'b0);  // R4 low bit

    // R10: the build without a data-in path returns zero; miso idles high here.
    begin
      int cyc;
      @(negedge clk);
      start_nm = 1'b1;
      @(negedge clk);
      start_nm = 1'b0;
      cyc = 1;
      while (busy_nm) begin
        @(negedge clk);
        if (busy_nm) cyc++;
      end
      chk(cyc == 108 * HN, "R10 busy length", cyc, 108 * HN);
      chk(rdata_nm == 16'h0000, "R10 read zero", rdata_nm, 0);
      chk(cs_nm && sck_nm && mosi_nm, "R10 idle lines", {cs_nm, sck_nm, mosi_nm}, 3'b111);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule